// File: doc/BRIEF.md
# Masked Vector Add Unit

This unit adds two integer source vectors element by element and writes the sums to a destination vector. A per-element mask controls which elements take effect. An element whose mask bit is clear is a no-op, and its destination element keeps its old value. A run starts with a one-cycle start pulse. At that pulse the unit captures the mask, the vector length and the mode select. It then drives a read index to the two source read ports, which return data in the same cycle. Results come out on a destination write port, with a write strobe, after a two-stage pipeline.

There are two modes. In full-sweep mode every element below the vector length goes through the datapath, one per cycle, and the captured mask bit gates the write strobe. In skip mode a priority search finds the next set mask bit, at or above the current index, in one cycle. Only those elements are issued, back to back, so the run time follows the number of set bits rather than the length. In both modes elements go in ascending index order. A one-cycle done pulse closes every run, including runs that issue nothing.

Top module: `masked_vadd_unit`

## Requirements
- R1: After reset, `wr_en`, `done` and `busy` are all 0.
- R2: In full-sweep mode (`skip_mode`=0), elements 0 to VL-1 are issued, one per cycle, in ascending order. Issue slot k (k from 0) is issued at clock edge k+1 after the edge that accepts `start`, and its write-port cycle follows at edge k+2. `wr_en` in that cycle equals the captured mask bit of the element.
- R3: When `wr_en` is 1, `wr_idx` names the element and `wr_data` equals (src_a + src_b) mod 2^DATA_W for that element's operands.
- R4: An element whose mask bit (bit i of `mask` stands for element i) is 0 never raises `wr_en`, so its destination element is left unchanged.
- R5: In skip mode (`skip_mode`=1), only the elements with a set mask bit below VL are issued. They go back to back in ascending order, with the same slot timing as R2, and the number of issue cycles equals the number of such set bits.
- R6: When n ≥ 1 elements are issued, `done` is a single-cycle pulse at edge n+3 after acceptance. This is after the last write. `busy` is 1 from acceptance until that edge.
- R7: When VL = 0, or in skip mode when no mask bit below VL is set, no write occurs and `done` pulses at edge 2 after acceptance.
- R8: Mask bits at indices VL and above have no effect in either mode.
- R9: While `busy` is 1, `start` is ignored. Changes to `mask`, `vlen` and `skip_mode` after acceptance do not affect the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; accepted only when idle |
| skip_mode | input | 1 | 0 = full sweep, 1 = skip masked-off elements |
| vlen | input | LEN_W | Vector length, 0 to MAX_VL |
| mask | input | MAX_VL | One enable bit per element |
| rd_idx | output | IDX_W | Element index presented to both source read ports |
| src_a | input | DATA_W | First operand for `rd_idx`, same cycle |
| src_b | input | DATA_W | Second operand for `rd_idx`, same cycle |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | IDX_W | Destination element index |
| wr_data | output | DATA_W | Destination element value |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default MAX_VL = 16 and DATA_W = 16. With these values every vector length from 0 up to the full register can be applied in a few dozen cycles. The same sizes make the all-ones and all-zero masks, masks set only above VL, and the last element (index 15) easy to reach. Sixteen-bit operands drawn at random make the modular wrap of the sum happen often.

// File: rtl/masked_vadd_unit.sv
module masked_vadd_unit #(
  parameter int DATA_W = 16,
  parameter int MAX_VL = 16,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int LEN_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              skip_mode,
  input  logic [LEN_W-1:0]  vlen,
  input  logic [MAX_VL-1:0] mask,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);

  logic              run, fin, skip_r;
  logic [LEN_W-1:0]  cur, len_r;
  logic [MAX_VL-1:0] mask_r;

  logic              hit;
  logic [IDX_W-1:0]  nxt;

  always_comb begin
    hit = 1'b0;
    nxt = '0;
    for (int i = MAX_VL - 1; i >= 0; i--) begin
      if (mask_r[i] && (i < int'(len_r)) && (i >= int'(cur))) begin
        hit = 1'b1;
        nxt = IDX_W'(i);
      end
    end
  end

  logic             issue, iss_we;
  logic [IDX_W-1:0] iss_idx;

  assign iss_idx = skip_r ? nxt : cur[IDX_W-1:0];
  assign issue   = run && (skip_r ? hit : (cur < len_r));
  assign iss_we  = skip_r ? 1'b1 : mask_r[iss_idx];
  assign rd_idx  = iss_idx;

  logic              v1, m1, v2, m2;
  logic [IDX_W-1:0]  i1, i2;
  logic [DATA_W-1:0] a1, b1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      fin    <= 1'b0;
      skip_r <= 1'b0;
      cur    <= '0;
      len_r  <= '0;
      mask_r <= '0;
      done   <= 1'b0;
      v1 <= 1'b0; m1 <= 1'b0; i1 <= '0; a1 <= '0; b1 <= '0;
      v2 <= 1'b0; m2 <= 1'b0; i2 <= '0; s2 <= '0;
    end else begin
      done <= 1'b0;
      if (!run && !fin) begin
        if (start) begin
          run    <= 1'b1;
          cur    <= '0;
          len_r  <= vlen;
          mask_r <= mask;
          skip_r <= skip_mode;
        end
      end else if (run) begin
        if (issue) begin
          cur <= LEN_W'(iss_idx) + LEN_W'(1);
        end else begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end else if (!v1 && !v2) begin
        fin  <= 1'b0;
        done <= 1'b1;
      end
      v1 <= issue;
      m1 <= iss_we;
      i1 <= iss_idx;
      a1 <= src_a;
      b1 <= src_b;
      v2 <= v1;
      m2 <= m1;
      i2 <= i1;
      s2 <= a1 + b1;
    end
  end

  assign wr_en   = v2 & m2;
  assign wr_idx  = i2;
  assign wr_data = s2;
  assign busy    = run | fin;

endmodule

// File: rtl/masked_vadd_unit_chk.sv
module masked_vadd_unit_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             busy,
  input logic             done
);

  p_wr_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  p_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_idx > $past(wr_idx)));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_en && !busy));

  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

bind masked_vadd_unit masked_vadd_unit_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
  .busy(busy), .done(done)
);

// File: tb/masked_vadd_unit_tb_top.sv
module masked_vadd_unit_tb_top;
  localparam int DW = 16;
  localparam int VL = 16;
  localparam int IW = $clog2(VL);
  localparam int LW = $clog2(VL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, skip_mode = 1'b0;
  logic [LW-1:0] vlen = '0;
  logic [VL-1:0] mask = '0;
  logic [IW-1:0] rd_idx, wr_idx;
  logic [DW-1:0] src_a, src_b, wr_data;
  logic wr_en, busy, done;

  logic [DW-1:0] mem_a [VL];
  logic [DW-1:0] mem_b [VL];

  always #10 clk = ~clk;

  assign src_a = mem_a[rd_idx];
  assign src_b = mem_b[rd_idx];

  masked_vadd_unit #(.DATA_W(DW), .MAX_VL(VL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_mode(skip_mode),
    .vlen(vlen), .mask(mask), .rd_idx(rd_idx), .src_a(src_a), .src_b(src_b),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected < 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit skp, input int len, input logic [VL-1:0] m,
                        input bit poke, input string tag);
    int s_idx[$];
    bit s_m[$];
    int n, dc, wr_seen, wr_exp;
    for (int i = 0; i < VL; i++) begin
      mem_a[i] = DW'($urandom);
      mem_b[i] = DW'($urandom);
    end
    wr_exp = 0;
    for (int i = 0; i < len; i++) begin
      if (!skp || m[i]) begin
        s_idx.push_back(i);
        s_m.push_back(m[i]);
      end
      if (m[i]) wr_exp++;
    end
    n = s_idx.size();
    dc = (n == 0) ? 2 : n + 3;
    @(negedge clk);
    skip_mode = skp; vlen = LW'(len); mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mask = ~m; vlen = LW'(VL - len); skip_mode = ~skp;
    wr_seen = 0;
    for (int c = 1; c <= dc; c++) begin
      @(negedge clk);
      if (c >= 2 && c - 2 < n) begin
        chk(wr_en == s_m[c-2], s_m[c-2] ? (skp ? "R5" : "R2") : "R4",
            "wr_en", wr_en, s_m[c-2]);
        if (s_m[c-2]) begin
          chk(wr_idx == IW'(s_idx[c-2]), skp ? "R5" : "R2", "wr_idx",
              wr_idx, s_idx[c-2]);
          chk(wr_data == DW'(mem_a[s_idx[c-2]] + mem_b[s_idx[c-2]]), "R3",
              "wr_data", wr_data, DW'(mem_a[s_idx[c-2]] + mem_b[s_idx[c-2]]));
        end
      end else begin
        chk(wr_en == 1'b0, (n == 0) ? "R7" : "R4", "wr_en idle slot", wr_en, 0);
      end
      if (wr_en) wr_seen++;
      chk(done == (c == dc), (n == 0) ? "R7" : "R6", "done", done, c == dc);
      chk(busy == (c < dc), "R6", "busy", busy, c < dc);
      if (poke && c == 2) begin
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(wr_seen == wr_exp, tag, "write count", wr_seen, wr_exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_en == 0 && done == 0 && busy == 0, "R1", "reset outputs",
        {wr_en, done, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_en == 0 && done == 0 && busy == 0, "R1", "idle outputs",
        {wr_en, done, busy}, 0);

    run_op(0, 8, 16'h00B2, 0, "R2");
    run_op(1, 8, 16'h00B2, 0, "R5");
    run_op(0, 16, 16'hFFFF, 0, "R2");
    run_op(1, 16, 16'hFFFF, 0, "R5");
    run_op(1, 16, 16'h8001, 0, "R5");
    run_op(0, 0, 16'hFFFF, 0, "R7");
    run_op(1, 0, 16'hFFFF, 0, "R7");
    run_op(1, 12, 16'h0000, 0, "R7");
    run_op(0, 10, 16'h0000, 0, "R4");
    run_op(1, 5, 16'hFFE0, 0, "R8");
    run_op(0, 6, 16'hFF21, 0, "R8");
    run_op(1, 6, 16'hFF21, 0, "R8");
    run_op(0, 9, 16'h0155, 1, "R9");
    run_op(1, 9, 16'h0155, 1, "R9");
    for (int k = 0; k < 24; k++)
      run_op(bit'(k % 2), int'($urandom_range(0, VL)), VL'($urandom), bit'(k % 3 == 0), "R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule